// File: doc/BRIEF.md
# Event Counter Bank with Overflow Status

The block holds a set of programmable event counters and a smaller set of fixed-purpose counters, as used by a performance-monitoring unit. Each programmable counter picks one of several event inputs through a select register. That register also holds a local enable, privilege filters, an interrupt request bit and an optional threshold. The threshold compares a per-event, per-cycle count against a minimum value. Each fixed counter is wired to its own event line and is controlled by a four-bit nibble in one shared control register.

Counting needs two things: the counter's local enable condition, and its bit in a shared global enable register. When a counter wraps from all-ones to zero, it sets its bit in a shared overflow status register. Software clears those bits by writing a mask of ones to a clear address. The interrupt line is a level. It is high while any status bit whose counter requests an interrupt is set.

Software reaches everything through one synchronous write port and one combinational read port. A counter may be rewritten while it runs.

Top module: `evc_bank`

## Requirements
- R1: After reset, every counter, select register, the fixed control register, the global enable register and the overflow status read zero, and irq is low.
- R2: A programmable counter adds one on each clock edge where all of the following hold: its select enable bit 22 is set; its global enable bit is set; the privilege filter passes; and the event chosen by select bits [15:0] pulses. The privilege filter uses bit 16 when priv_user is 1 and bit 17 when priv_user is 0. The chosen event must be below the event count, and this rule applies when the threshold field is zero.
- R3: Clearing either the global enable bit or the local enable bit freezes the count.
- R4: When select bits [31:24] hold a nonzero threshold, the counter adds one in each enabled cycle where the chosen event's per-cycle count is at least the threshold. The event pulse is then ignored.
- R5: Fixed counter j is controlled by bits [4j+3:4j] of the fixed control register. Within that nibble, bit 0 allows counting at priv_user=0, bit 1 allows counting at priv_user=1, and bit 3 requests an interrupt. The counter counts pulses on fix_evt[j] while its global enable bit 32+j is set.
- R6: A counter stepping from all-ones to zero sets the status bit at its global index. Programmable counter i uses index i, and fixed counter j uses index 32+j.
- R7: Writing a mask to the clear address clears the status bits that are one in the mask. An overflow in the same cycle still sets its bit.
- R8: irq is high exactly while some status bit is set whose counter has its interrupt bit set (select bit 20 or nibble bit 3). An overflow without that bit only sets status.
- R9: A counter write takes effect at the next edge in place of any increment in that cycle, and counting continues from the written value. Writing all-ones and then counting one event overflows.
- R10: The read port returns the addressed register zero-extended: 0x00+i counter, 0x10+i select, 0x20+j fixed counter, 0x30 fixed control, 0x31 global enable, 0x32 status. The clear address is 0x33. Unimplemented global enable bits and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 64 | Read data (combinational) |
| priv_user | input | 1 | Current privilege: 1 user, 0 kernel |
| evt_pulse | input | NUM_EVT | Per-cycle event pulses |
| evt_num | input | NUM_EVT*NUM_W | Per-event count this cycle, packed |
| fix_evt | input | NUM_FIX | Fixed-counter event pulses |
| ovf_status | output | 64 | Overflow status register |
| irq | output | 1 | Overflow interrupt level |

## Verification
Programmable counters are driven with pulses on the selected event, on a different event, and under the mismatching privilege. This separates the event decode from the privilege filter. Threshold mode is tried with per-cycle counts below, equal to and above the threshold while the pulse is held opposite to the count, which shows that the pulse is ignored. Wraps are forced by preloading all-ones, with and without the interrupt bit, and with a clear write landing in the same cycle. This tells a status set apart from an interrupt and shows which of set and clear wins. A write to a counter that is running distinguishes replacing the count from adding to it.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int REG_W    = 64;
    localparam int ADDR_W   = 8;
    localparam int SEL_W    = 32;
    localparam int THR_W    = 8;
    localparam int FIX_BASE = 32;

    localparam logic [ADDR_W-1:0] A_GP_CTR  = 8'h00;
    localparam logic [ADDR_W-1:0] A_GP_SEL  = 8'h10;
    localparam logic [ADDR_W-1:0] A_FIX_CTR = 8'h20;
    localparam logic [ADDR_W-1:0] A_FIX_CTL = 8'h30;
    localparam logic [ADDR_W-1:0] A_GBL_EN  = 8'h31;
    localparam logic [ADDR_W-1:0] A_STATUS  = 8'h32;
    localparam logic [ADDR_W-1:0] A_CLR     = 8'h33;

    localparam int SEL_USR     = 16;
    localparam int SEL_KRN     = 17;
    localparam int SEL_INT     = 20;
    localparam int SEL_EN      = 22;
    localparam int SEL_THR_LSB = 24;

    localparam int FIX_KRN = 0;
    localparam int FIX_USR = 1;
    localparam int FIX_INT = 3;
endpackage

// File: rtl/evc_gp_ctr.sv
module evc_gp_ctr
    import evc_pkg::*;
#(
    parameter int CTR_W   = 48,
    parameter int NUM_EVT = 8,
    parameter int NUM_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_wr,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic                     cnt_wr,
    input  logic [CTR_W-1:0]         wr_cnt,
    input  logic                     gbl_en,
    input  logic                     priv_user,
    input  logic [NUM_EVT-1:0]       evt_pulse,
    input  logic [NUM_EVT*NUM_W-1:0] evt_num,
    output logic [CTR_W-1:0]         cnt,
    output logic [SEL_W-1:0]         sel,
    output logic                     ovf,
    output logic                     irq_en
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } gp_state_t;

    gp_state_t s_d, s_q;
    logic [IDX_W-1:0] idx;
    logic [NUM_W-1:0] num;
    logic [THR_W-1:0] thr;
    logic             code_ok, priv_ok, hit, inc;

    always_comb begin
        idx     = s_q.sel[IDX_W-1:0];
        code_ok = (32'(s_q.sel[15:0]) < NUM_EVT);
        num     = evt_num[idx*NUM_W +: NUM_W];
        thr     = s_q.sel[SEL_THR_LSB +: THR_W];
        priv_ok = priv_user ? s_q.sel[SEL_USR] : s_q.sel[SEL_KRN];
        hit     = (thr == '0) ? evt_pulse[idx] : (32'(num) >= 32'(thr));
        inc     = code_ok && s_q.sel[SEL_EN] && gbl_en && priv_ok && hit;

        s_d = s_q;
        if (sel_wr) s_d.sel = wr_sel;
        if (cnt_wr) s_d.cnt = wr_cnt;
        else if (inc) s_d.cnt = s_q.cnt + {{(CTR_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt    = s_q.cnt;
    assign sel    = s_q.sel;
    assign ovf    = inc && !cnt_wr && (&s_q.cnt);
    assign irq_en = s_q.sel[SEL_INT];
endmodule

// File: rtl/evc_fix_ctr.sv
module evc_fix_ctr #(
    parameter int CTR_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             krn_en,
    input  logic             usr_en,
    input  logic             gbl_en,
    input  logic             priv_user,
    input  logic             evt,
    input  logic             cnt_wr,
    input  logic [CTR_W-1:0] wr_cnt,
    output logic [CTR_W-1:0] cnt,
    output logic             ovf
);
    typedef struct packed {
        logic [CTR_W-1:0] cnt;
    } fix_state_t;

    fix_state_t s_d, s_q;
    logic       inc;

    always_comb begin
        inc = evt && gbl_en && (priv_user ? usr_en : krn_en);
        s_d = s_q;
        if (cnt_wr) s_d.cnt = wr_cnt;
        else if (inc) s_d.cnt = s_q.cnt + {{(CTR_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign ovf = inc && !cnt_wr && (&s_q.cnt);
endmodule

// File: rtl/evc_status.sv
module evc_status
    import evc_pkg::*;
#(
    parameter int NUM_GP  = 4,
    parameter int NUM_FIX = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GP-1:0]  ovf_gp,
    input  logic [NUM_FIX-1:0] ovf_fix,
    input  logic [NUM_GP-1:0]  ie_gp,
    input  logic [NUM_FIX-1:0] ie_fix,
    input  logic [NUM_GP-1:0]  clr_gp,
    input  logic [NUM_FIX-1:0] clr_fix,
    output logic [REG_W-1:0]   status,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_GP-1:0]  gp;
        logic [NUM_FIX-1:0] fix;
    } st_state_t;

    st_state_t s_d, s_q;

    always_comb begin
        s_d.gp  = (s_q.gp  & ~clr_gp)  | ovf_gp;
        s_d.fix = (s_q.fix & ~clr_fix) | ovf_fix;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        status = '0;
        status[NUM_GP-1:0]          = s_q.gp;
        status[FIX_BASE +: NUM_FIX] = s_q.fix;
    end

    assign irq = (|(s_q.gp & ie_gp)) | (|(s_q.fix & ie_fix));
endmodule

// File: rtl/evc_bank.sv
module evc_bank
    import evc_pkg::*;
#(
    parameter int NUM_GP  = 4,
    parameter int NUM_FIX = 3,
    parameter int CTR_W   = 48,
    parameter int NUM_EVT = 8,
    parameter int NUM_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [7:0]               wr_addr,
    input  logic [63:0]              wr_data,
    input  logic [7:0]               rd_addr,
    output logic [63:0]              rd_data,
    input  logic                     priv_user,
    input  logic [NUM_EVT-1:0]       evt_pulse,
    input  logic [NUM_EVT*NUM_W-1:0] evt_num,
    input  logic [NUM_FIX-1:0]       fix_evt,
    output logic [63:0]              ovf_status,
    output logic                     irq
);
    localparam int CTL_W = 4 * NUM_FIX;

    typedef struct packed {
        logic [CTL_W-1:0]   fix_ctl;
        logic [NUM_GP-1:0]  gbl_gp;
        logic [NUM_FIX-1:0] gbl_fix;
    } top_state_t;

    top_state_t s_d, s_q;
    logic [NUM_GP-1:0][CTR_W-1:0]  gp_cnt;
    logic [NUM_GP-1:0][SEL_W-1:0]  gp_sel;
    logic [NUM_FIX-1:0][CTR_W-1:0] fix_cnt;
    logic [NUM_GP-1:0]  ovf_gp, ie_gp, gp_cnt_wr, gp_sel_wr;
    logic [NUM_FIX-1:0] ovf_fix, ie_fix, fix_cnt_wr;
    logic [NUM_GP-1:0]  gbl_gp_q;
    logic               clr_wr;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign clr_wr         = wr_en && (wr_addr == A_CLR);
    assign gbl_gp_q       = s_q.gbl_gp;

    always_comb begin
        s_d = s_q;
        if (wr_en && wr_addr == A_FIX_CTL) s_d.fix_ctl = wr_data[CTL_W-1:0];
        if (wr_en && wr_addr == A_GBL_EN) begin
            s_d.gbl_gp  = wr_data[NUM_GP-1:0];
            s_d.gbl_fix = wr_data[FIX_BASE +: NUM_FIX];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
        assign gp_cnt_wr[i] = wr_en && (wr_addr == A_GP_CTR + 8'(i));
        assign gp_sel_wr[i] = wr_en && (wr_addr == A_GP_SEL + 8'(i));
        evc_gp_ctr #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .NUM_W(NUM_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_wr    (gp_sel_wr[i]),
            .wr_sel    (wr_data[SEL_W-1:0]),
            .cnt_wr    (gp_cnt_wr[i]),
            .wr_cnt    (wr_data[CTR_W-1:0]),
            .gbl_en    (s_q.gbl_gp[i]),
            .priv_user (priv_user),
            .evt_pulse (evt_pulse),
            .evt_num   (evt_num),
            .cnt       (gp_cnt[i]),
            .sel       (gp_sel[i]),
            .ovf       (ovf_gp[i]),
            .irq_en    (ie_gp[i])
        );
    end

    for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix
        assign fix_cnt_wr[j] = wr_en && (wr_addr == A_FIX_CTR + 8'(j));
        assign ie_fix[j]     = s_q.fix_ctl[4*j + FIX_INT];
        evc_fix_ctr #(.CTR_W(CTR_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .krn_en    (s_q.fix_ctl[4*j + FIX_KRN]),
            .usr_en    (s_q.fix_ctl[4*j + FIX_USR]),
            .gbl_en    (s_q.gbl_fix[j]),
            .priv_user (priv_user),
            .evt       (fix_evt[j]),
            .cnt_wr    (fix_cnt_wr[j]),
            .wr_cnt    (wr_data[CTR_W-1:0]),
            .cnt       (fix_cnt[j]),
            .ovf       (ovf_fix[j])
        );
    end

    evc_status #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_gp  (ovf_gp),
        .ovf_fix (ovf_fix),
        .ie_gp   (ie_gp),
        .ie_fix  (ie_fix),
        .clr_gp  (clr_wr ? wr_data[NUM_GP-1:0] : '0),
        .clr_fix (clr_wr ? wr_data[FIX_BASE +: NUM_FIX] : '0),
        .status  (ovf_status),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            if (rd_addr == A_GP_CTR + 8'(i)) rd_data = 64'(gp_cnt[i]);
            if (rd_addr == A_GP_SEL + 8'(i)) rd_data = 64'(gp_sel[i]);
        end
        for (int j = 0; j < NUM_FIX; j++) begin
            if (rd_addr == A_FIX_CTR + 8'(j)) rd_data = 64'(fix_cnt[j]);
        end
        if (rd_addr == A_FIX_CTL) rd_data = 64'(s_q.fix_ctl);
        if (rd_addr == A_GBL_EN) begin
            rd_data[NUM_GP-1:0]          = s_q.gbl_gp;
            rd_data[FIX_BASE +: NUM_FIX] = s_q.gbl_fix;
        end
        if (rd_addr == A_STATUS) rd_data = ovf_status;
    end
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
    import evc_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int CTR_W  = 48
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [7:0]               wr_addr,
    input logic [63:0]              wr_data,
    input logic [NUM_GP-1:0]        gbl_gp,
    input logic [NUM_GP-1:0][CTR_W-1:0] gp_cnt,
    input logic [63:0]              ovf_status,
    input logic                     irq
);
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_status != '0)); // R8

    for (genvar i = 0; i < NUM_GP; i++) begin : g_chk
        AST_FROZEN_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (!gbl_gp[i] && !(wr_en && wr_addr == A_GP_CTR + 8'(i))) |=> $stable(gp_cnt[i])); // R3
        AST_STATUS_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_status[i]) |-> ((&$past(gp_cnt[i])) && gp_cnt[i] == '0)); // R6
        AST_STATUS_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ovf_status[i]) |-> $past(wr_en && wr_addr == A_CLR && wr_data[i])); // R7
    end
endmodule

bind evc_bank evc_bank_chk #(.NUM_GP(NUM_GP), .CTR_W(CTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .gbl_gp     (gbl_gp_q),
    .gp_cnt     (gp_cnt),
    .ovf_status (ovf_status),
    .irq        (irq)
);

// File: tb/test_evc_bank.sv
`timescale 1ns/1ps
module test_evc_bank;
    import evc_pkg::*;

    localparam int NUM_GP = 4, NUM_FIX = 3, CTR_W = 48, NUM_EVT = 8, NUM_W = 4;
    localparam logic [63:0] ONES = (64'd1 << CTR_W) - 64'd1;
    localparam logic [63:0] EN = 64'd1 << SEL_EN, USR = 64'd1 << SEL_USR;
    localparam logic [63:0] KRN = 64'd1 << SEL_KRN, INT = 64'd1 << SEL_INT;
    localparam logic [7:0] IRQ_PSEUDO = 8'hFF;

    logic clk = 0, rst_n = 0, wr_en = 0, priv_user = 0;
    logic [7:0] wr_addr = 0, rd_addr = 0;
    logic [63:0] wr_data = 0, rd_data, ovf_status;
    logic [NUM_EVT-1:0] evt_pulse = 0;
    logic [NUM_EVT*NUM_W-1:0] evt_num = 0;
    logic [NUM_FIX-1:0] fix_evt = 0;
    logic irq;

    typedef struct { logic [7:0] addr; logic [63:0] exp; string tag; } item_t;
    item_t sb[$];
    int vectors = 0, miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evc_bank #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .CTR_W(CTR_W),
               .NUM_EVT(NUM_EVT), .NUM_W(NUM_W)) i_evc_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .priv_user(priv_user),
        .evt_pulse(evt_pulse), .evt_num(evt_num), .fix_evt(fix_evt),
        .ovf_status(ovf_status), .irq(irq));

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it  = sb.pop_front();
            act = (it.addr == IRQ_PSEUDO) ? {63'd0, irq} : rd_data;
            vectors++;
            if (act !== it.exp) begin
                miscompares++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [63:0] e, input string tag);
        item_t it;
        rd_addr = (a == IRQ_PSEUDO) ? 8'h00 : a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++; miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        expect_rd(A_GP_CTR, 0, "R1 gp counter");
        expect_rd(A_GP_SEL, 0, "R1 select");
        expect_rd(A_FIX_CTL, 0, "R1 fixed control");
        expect_rd(A_GBL_EN, 0, "R1 global enable");
        expect_rd(A_STATUS, 0, "R1 status");
        expect_rd(IRQ_PSEUDO, 0, "R1 irq");

        // R2 basic counting, event decode and privilege filter
        wr(A_GP_SEL, EN | USR | 64'd2);
        wr(A_GBL_EN, 64'h1);
        priv_user = 1;
        evt_pulse[2] = 1; hold(10); evt_pulse[2] = 0;
        expect_rd(A_GP_CTR, 64'd10, "R2 ten user events");
        priv_user = 0;
        evt_pulse[2] = 1; hold(5); evt_pulse[2] = 0;
        expect_rd(A_GP_CTR, 64'd10, "R2 kernel filtered");
        priv_user = 1;
        evt_pulse[3] = 1; hold(5); evt_pulse[3] = 0;
        expect_rd(A_GP_CTR, 64'd10, "R2 other event ignored");

        // R3 freezing by global or local enable
        wr(A_GBL_EN, 64'h0);
        evt_pulse[2] = 1; hold(5); evt_pulse[2] = 0;
        expect_rd(A_GP_CTR, 64'd10, "R3 global off");
        wr(A_GBL_EN, 64'h1);
        wr(A_GP_SEL, USR | 64'd2);
        evt_pulse[2] = 1; hold(5); evt_pulse[2] = 0;
        expect_rd(A_GP_CTR, 64'd10, "R3 local off");

        // R4 threshold mode
        wr(A_GP_CTR, 64'd0);
        wr(A_GP_SEL, EN | USR | 64'd2 | (64'd3 << SEL_THR_LSB));
        evt_num[2*NUM_W +: NUM_W] = 4'd2; evt_pulse[2] = 1; hold(4); evt_pulse[2] = 0;
        expect_rd(A_GP_CTR, 64'd0, "R4 below threshold");
        evt_num[2*NUM_W +: NUM_W] = 4'd3; hold(4);
        expect_rd(A_GP_CTR, 64'd4, "R4 equal threshold");
        evt_num[2*NUM_W +: NUM_W] = 4'd5; hold(2); evt_num = '0;
        expect_rd(A_GP_CTR, 64'd6, "R4 above threshold");

        // R9 write to a running counter
        wr(A_GP_SEL, EN | USR | 64'd2);
        evt_pulse[2] = 1;
        @(posedge clk); #1;
        wr_en = 1; wr_addr = A_GP_CTR; wr_data = 64'd100;
        @(posedge clk); #1;
        wr_en = 0;
        hold(3); evt_pulse[2] = 0;
        expect_rd(A_GP_CTR, 64'd103, "R9 continue from written value");

        // R6 / R8 / R9 wrap without interrupt on counter 1
        priv_user = 0;
        wr(A_GP_SEL + 8'd1, EN | KRN | 64'd0);
        wr(A_GBL_EN, 64'h3);
        wr(A_GP_CTR + 8'd1, ONES);
        evt_pulse[0] = 1; hold(1); evt_pulse[0] = 0;
        expect_rd(A_GP_CTR + 8'd1, 64'd0, "R6 wrapped to zero");
        expect_rd(A_STATUS, 64'h2, "R6 status bit 1");
        expect_rd(IRQ_PSEUDO, 0, "R8 no interrupt without enable");
        // R7 clear, then set wins over same-cycle clear
        wr(A_CLR, 64'h2);
        expect_rd(A_STATUS, 64'h0, "R7 cleared");
        wr(A_GP_CTR + 8'd1, ONES);
        @(posedge clk); #1;
        evt_pulse[0] = 1; wr_en = 1; wr_addr = A_CLR; wr_data = 64'h2;
        @(posedge clk); #1;
        evt_pulse[0] = 0; wr_en = 0;
        expect_rd(A_STATUS, 64'h2, "R7 overflow wins over clear");
        wr(A_CLR, 64'h2);

        // R5 fixed counters
        wr(A_FIX_CTL, 64'h920);
        wr(A_GBL_EN, 64'h6_0000_0003);
        priv_user = 1;
        fix_evt = 3'b011; hold(7); fix_evt = 0;
        expect_rd(A_FIX_CTR + 8'd1, 64'd7, "R5 fixed user count");
        expect_rd(A_FIX_CTR, 64'd0, "R5 fixed without nibble");
        priv_user = 0;
        fix_evt = 3'b010; hold(3); fix_evt = 0;
        expect_rd(A_FIX_CTR + 8'd1, 64'd7, "R5 fixed kernel filtered");

        // R6 / R8 fixed wrap with interrupt
        wr(A_FIX_CTR + 8'd2, ONES - 64'd1);
        fix_evt = 3'b100; hold(2); fix_evt = 0;
        expect_rd(A_STATUS, 64'h4_0000_0000, "R6 fixed status bit 34");
        expect_rd(IRQ_PSEUDO, 1, "R8 interrupt raised");
        wr(A_CLR, 64'h1);
        expect_rd(IRQ_PSEUDO, 1, "R8 level held after unrelated clear");
        wr(A_CLR, 64'h4_0000_0000);
        expect_rd(IRQ_PSEUDO, 0, "R8 level dropped");
        expect_rd(A_STATUS, 64'h0, "R7 fixed bit cleared");

        // R10 read map
        wr(A_GBL_EN, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_rd(A_GBL_EN, 64'h0000_0007_0000_000F, "R10 global enable readback");
        expect_rd(A_GP_SEL + 8'd1, EN | KRN, "R10 select readback");
        expect_rd(8'h40, 64'd0, "R10 unmapped address");

        done = 1;
        @(posedge clk);
        summary();
    end
endmodule